// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of a small serial EEPROM that stores 16-bit words. A host talks to it over four pins: a chip select, a serial clock, a serial data input and a serial data output. While chip select is high, the host shifts in a start bit, a two-bit opcode and an address (MSB first). WRITE and the fill-all command also take a 16-bit data field. READ returns the stored word on the data output. Address width is a parameter, 6 or 8 bits.

The serial pins are synchronised to a fast system clock `clk`, and only rising edges of the serial clock advance the device. Programming commands (single write, single erase, erase-all, fill-all) only take effect once an unlock command has set the write-enable latch. A lock command clears that latch again. After an accepted programming command the device is busy for a fixed number of rising serial clock edges. When the host raises chip select again, the data output shows that state: 0 while busy and 1 once ready. The storage is a register array inside the block.

Top module: `ee_microwire_dev`

## Requirements
- R1: A command begins at the first rising serial clock edge, with chip select high and the device ready, that samples a 1 on the data input. Zeros sampled before it are ignored.
- R2: READ (opcode 10) drives 0 on the data output as soon as the last address bit is taken. Each later rising serial clock edge presents the next bit of the addressed word, from bit 15 down to bit 0.
- R3: WRITE (opcode 01) with the latch set stores the 16 data bits that follow the address (MSB first) at that address.
- R4: The write-enable latch is clear after reset. While it is clear, every programming command leaves the stored words unchanged and does not start a busy period.
- R5: ERASE (opcode 11) with the latch set makes the addressed word 0xFFFF and leaves the other words as they were.
- R6: Extended opcode 00 with top address bits 10 (erase-all) and the latch set makes every word 0xFFFF.
- R7: Extended opcode 00 with top address bits 01 (fill-all), followed by 16 data bits, with the latch set writes that data to every word.
- R8: Extended opcode 00 with top address bits 11 sets the write-enable latch, and with 00 clears it. The lower address bits are ignored.
- R9: After an accepted programming command, with chip select high, the data output reads 0 until BUSY_EDGES rising serial clock edges have occurred after the one that completed the command. It then reads 1. No new start bit is taken while busy.
- R10: Lowering chip select returns the device to idle. A command cut short this way has no effect.
- R11: After reset every word reads 0xFFFF and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; its rising edges advance the device |
| di | input | 1 | Serial data input (start bit, opcode, address, data) |
| dout | output | 1 | Serial data output: read data or ready/busy status |

## Verification
Each pin passes SYNC_STAGES flops. One more flop stage detects the serial clock edge, and the state register updates on the cycle after that. Any result therefore appears on `dout` about SYNC_STAGES+2 system clocks after the pin change that caused it. The bench holds every serial clock phase for eight system clocks and samples `dout` at the end of the low phase, just before the next rising edge, so each read bit and each status value has settled. The busy window is counted in rising serial clock edges, so the bench checks for 0 after BUSY_EDGES-1 pulses and for 1 after BUSY_EDGES pulses.

// File: rtl/ee_pkg.sv
package ee_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t ERASED_WORD = '1;

    typedef enum logic [1:0] {
        OPC_EXT   = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_ERASE = 2'b11
    } opcode_e;

    // sub-function picked by the two top address bits of opcode 00
    typedef enum logic [1:0] {
        EXT_LOCK   = 2'b00,
        EXT_FILL   = 2'b01,
        EXT_CLEAR  = 2'b10,
        EXT_UNLOCK = 2'b11
    } ext_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_SHIFT_OUT,
        ST_DONE
    } state_e;

    function automatic logic needs_data(opcode_e op, ext_e ext);
        return (op == OPC_WRITE) || (op == OPC_EXT && ext == EXT_FILL);
    endfunction

    function automatic logic is_prog(opcode_e op, ext_e ext);
        return (op == OPC_WRITE) || (op == OPC_ERASE) ||
               (op == OPC_EXT && (ext == EXT_FILL || ext == EXT_CLEAR));
    endfunction

endpackage

// File: rtl/ee_pin_sync.sv
module ee_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_pin,
    input  logic sk_pin,
    input  logic di_pin,
    output logic cs_q,
    output logic di_q,
    output logic sk_rise
);
    logic [SYNC_STAGES-1:0] cs_r;
    logic [SYNC_STAGES-1:0] di_r;
    logic [SYNC_STAGES:0]   sk_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_r <= '0;
            di_r <= '0;
            sk_r <= '0;
        end else begin
            cs_r <= {cs_r[SYNC_STAGES-2:0], cs_pin};
            di_r <= {di_r[SYNC_STAGES-2:0], di_pin};
            sk_r <= {sk_r[SYNC_STAGES-1:0], sk_pin};
        end
    end

    assign cs_q    = cs_r[SYNC_STAGES-1];
    assign di_q    = di_r[SYNC_STAGES-1];
    assign sk_rise = sk_r[SYNC_STAGES-1] & ~sk_r[SYNC_STAGES];

    AST_SK_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sk_rise |=> !sk_rise); // R2

endmodule

// File: rtl/ee_busy_timer.sv
module ee_busy_timer #(
    parameter int BUSY_EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic busy
);
    localparam int CW = $clog2(BUSY_EDGES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(BUSY_EDGES);
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= BUSY_EDGES); // R9

    AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (!start && tick && busy) |=> (cnt == $past(cnt) - 1'b1)); // R9

endmodule

// File: rtl/ee_word_array.sv
module ee_word_array
    import ee_pkg::*;
#(
    parameter int ADDR_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_go,
    input  logic                 prog_all,
    input  logic [ADDR_BITS-1:0] prog_addr,
    input  word_t                prog_data,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output word_t                rd_data
);
    localparam int DEPTH = 1 << ADDR_BITS;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= ERASED_WORD;
        end else if (prog_go) begin
            if (prog_all) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= prog_data;
            end else begin
                mem[prog_addr] <= prog_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

    AST_FILL_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (prog_go && prog_all) |=> (mem[0] == mem[DEPTH-1])); // R7

endmodule

// File: rtl/ee_microwire_dev.sv
module ee_microwire_dev
    import ee_pkg::*;
#(
    parameter int ADDR_BITS   = 6,
    parameter int BUSY_EDGES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout
);
    localparam int MAX_FIELD = (WORD_W > ADDR_BITS) ? WORD_W : ADDR_BITS;
    localparam int CNT_W     = $clog2(MAX_FIELD);

    logic cs_q, di_q, sk_rise;
    logic busy;

    state_e               state;
    opcode_e              opc;
    logic [CNT_W-1:0]     cnt;
    logic [ADDR_BITS-1:0] adr;
    logic [WORD_W-2:0]    dat;
    logic [WORD_W:0]      rd_sh;
    logic                 wen;
    logic                 status_armed;

    logic [ADDR_BITS-1:0] adr_nx;
    word_t                dat_nx;
    ext_e                 ext_nx;
    logic                 step, addr_last, data_last;
    logic                 prog_go, prog_all;
    word_t                prog_data;
    logic [ADDR_BITS-1:0] prog_addr;
    word_t                rd_data;

    ee_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .cs_pin(cs), .sk_pin(sk), .di_pin(di),
        .cs_q(cs_q), .di_q(di_q), .sk_rise(sk_rise)
    );

    ee_busy_timer #(.BUSY_EDGES(BUSY_EDGES)) timer_i (
        .clk(clk), .rst(rst), .start(prog_go), .tick(sk_rise), .busy(busy)
    );

    ee_word_array #(.ADDR_BITS(ADDR_BITS)) array_i (
        .clk(clk), .rst(rst), .prog_go(prog_go), .prog_all(prog_all),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .rd_addr(adr_nx), .rd_data(rd_data)
    );

    assign adr_nx    = {adr[ADDR_BITS-2:0], di_q};
    assign dat_nx    = {dat, di_q};
    assign ext_nx    = ext_e'(adr_nx[ADDR_BITS-1 -: 2]);
    assign step      = sk_rise && cs_q;
    assign addr_last = step && state == ST_ADDR && cnt == CNT_W'(ADDR_BITS - 1);
    assign data_last = step && state == ST_DATA && cnt == CNT_W'(WORD_W - 1);
    assign prog_addr = (state == ST_ADDR) ? adr_nx : adr;

    // programming request: issued on the edge that completes the command
    always_comb begin
        prog_go   = 1'b0;
        prog_all  = 1'b0;
        prog_data = ERASED_WORD;
        if (addr_last && is_prog(opc, ext_nx) && !needs_data(opc, ext_nx)) begin
            prog_go  = wen;
            prog_all = (opc == OPC_EXT);
        end
        if (data_last) begin
            prog_go   = wen;
            prog_all  = (opc == OPC_EXT);
            prog_data = dat_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            opc          <= OPC_EXT;
            cnt          <= '0;
            adr          <= '0;
            dat          <= '0;
            rd_sh        <= '0;
            wen          <= 1'b0;
            status_armed <= 1'b0;
        end else if (!cs_q) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (sk_rise) begin
            case (state)
                ST_IDLE: begin
                    if (di_q && !busy) begin
                        state        <= ST_OPC;
                        cnt          <= '0;
                        status_armed <= 1'b0;
                    end
                end
                ST_OPC: begin
                    opc <= opcode_e'({opc[0], di_q});
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_ADDR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ADDR: begin
                    adr <= adr_nx;
                    if (addr_last) begin
                        cnt <= '0;
                        if (opc == OPC_READ) begin
                            rd_sh <= {1'b0, rd_data};
                            state <= ST_SHIFT_OUT;
                        end else if (needs_data(opc, ext_nx)) begin
                            state <= ST_DATA;
                        end else begin
                            state <= ST_DONE;
                            if (opc == OPC_EXT && ext_nx == EXT_UNLOCK)
                                wen <= 1'b1;
                            else if (opc == OPC_EXT && ext_nx == EXT_LOCK)
                                wen <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    dat <= dat_nx[WORD_W-2:0];
                    if (data_last)
                        state <= ST_DONE;
                    else
                        cnt <= cnt + 1'b1;
                end
                ST_SHIFT_OUT: rd_sh <= {rd_sh[WORD_W-1:0], 1'b0};
                default: ;
            endcase
            if (prog_go)
                status_armed <= 1'b1;
        end
    end

    always_comb begin
        if (cs_q && state == ST_SHIFT_OUT)
            dout = rd_sh[WORD_W];
        else if (cs_q && state == ST_IDLE && status_armed)
            dout = ~busy;
        else
            dout = 1'b0;
    end

    AST_CS_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cs_q |=> (state == ST_IDLE)); // R10

    AST_READ_DUMMY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT_OUT && $past(state) != ST_SHIFT_OUT && cs_q) |-> !dout); // R2

    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wen); // R4

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && state == ST_IDLE) |=> (state == ST_IDLE)); // R9

endmodule

// File: tb/ee_microwire_dev_tb_top.sv
module ee_microwire_dev_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AB         = 6;
    localparam int BUSY       = 4;
    localparam int PH         = 8;
    localparam int NVEC       = 6;

    // each entry: {address[5:0], data[15:0]}
    localparam logic [21:0] VEC [NVEC] = '{
        {6'd0,  16'hA5C3},
        {6'd63, 16'h0001},
        {6'd21, 16'h8000},
        {6'd42, 16'hFFFE},
        {6'd1,  16'h1234},
        {6'd62, 16'h0F0F}
    };

    logic clk = 1'b0;
    logic rst, cs, sk, di;
    logic dout;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ee_microwire_dev #(.ADDR_BITS(AB), .BUSY_EDGES(BUSY), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .dout(dout)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (PH) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        sk = 1'b0; di = b; hold();
        sk = 1'b1; hold();
    endtask

    task automatic pulse();
        sk = 1'b1; hold();
        sk = 1'b0; hold();
    endtask

    task automatic cs_on();
        sk = 1'b0; di = 1'b0; cs = 1'b1; hold();
    endtask

    task automatic cs_off();
        sk = 1'b0; di = 1'b0; cs = 1'b0; hold(); hold();
    endtask

    task automatic head(int lead, logic [1:0] op, logic [AB-1:0] a);
        for (int i = 0; i < lead; i++) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(op[1]);
        send_bit(op[0]);
        for (int i = AB-1; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic issue(logic [1:0] op, logic [AB-1:0] a, bit with_data, logic [15:0] d);
        cs_on();
        head(0, op, a);
        if (with_data)
            for (int i = 15; i >= 0; i--) send_bit(d[i]);
        cs_off();
    endtask

    task automatic read_chk(string tag, int lead, logic [AB-1:0] a, logic [15:0] exp);
        logic [15:0] w;
        cs_on();
        head(lead, 2'b10, a);
        di = 1'b0; sk = 1'b0; hold();
        chk({tag, " dummy bit R2"}, {15'd0, dout}, 16'h0000);
        w = '0;
        for (int i = 0; i < 16; i++) begin
            pulse();
            w = {w[14:0], dout};
        end
        chk(tag, w, exp);
        cs_off();
    endtask

    task automatic wait_ready(string tag);
        cs_on();
        chk({tag, " busy at raise R9"}, {15'd0, dout}, 16'h0000);
        repeat (BUSY-1) pulse();
        chk({tag, " busy before last edge R9"}, {15'd0, dout}, 16'h0000);
        pulse();
        chk({tag, " ready R9"}, {15'd0, dout}, 16'h0001);
        cs_off();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs = 1'b0; sk = 1'b0; di = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R11: reset state
        chk("R11 dout after reset", {15'd0, dout}, 16'h0000);
        read_chk("R11 word 0 erased", 0, 6'd0, 16'hFFFF);
        read_chk("R11 word 63 erased", 0, 6'd63, 16'hFFFF);

        // R4: write without unlock is ignored
        issue(2'b01, 6'd5, 1'b1, 16'h1234);
        cs_on();
        chk("R4 no busy status when locked", {15'd0, dout}, 16'h0000);
        cs_off();
        read_chk("R4 locked write ignored", 0, 6'd5, 16'hFFFF);

        // R8: unlock with don't-care low bits
        issue(2'b00, 6'b110101, 1'b0, 16'h0000);

        // R3: table of writes, each followed by ready poll and read-back
        for (int v = 0; v < NVEC; v++) begin
            issue(2'b01, VEC[v][21:16], 1'b1, VEC[v][15:0]);
            wait_ready("R9 write");
            read_chk("R3 write read-back", 0, VEC[v][21:16], VEC[v][15:0]);
        end

        // R5: single erase
        issue(2'b11, 6'd21, 1'b0, 16'h0000);
        wait_ready("R9 erase");
        read_chk("R5 erased word", 0, 6'd21, 16'hFFFF);
        read_chk("R5 neighbour kept", 0, 6'd42, 16'hFFFE);

        // R10: write aborted half-way through data
        cs_on();
        head(0, 2'b01, 6'd42);
        for (int i = 0; i < 8; i++) send_bit(1'b0);
        cs_off();
        read_chk("R10 aborted write no effect", 0, 6'd42, 16'hFFFE);

        // R1: leading zeros before start bit
        read_chk("R1 leading zeros ignored", 3, 6'd0, 16'hA5C3);

        // R7: fill all
        issue(2'b00, 6'b011100, 1'b1, 16'h5A5A);
        wait_ready("R9 fill");
        read_chk("R7 fill word 0", 0, 6'd0, 16'h5A5A);
        read_chk("R7 fill word 63", 0, 6'd63, 16'h5A5A);

        // R6: erase all
        issue(2'b00, 6'b100011, 1'b0, 16'h0000);
        wait_ready("R9 erase all");
        read_chk("R6 erase all word 17", 0, 6'd17, 16'hFFFF);
        read_chk("R6 erase all word 62", 0, 6'd62, 16'hFFFF);

        // R8 / R4: lock with don't-care low bits, then write is ignored
        issue(2'b00, 6'b001010, 1'b0, 16'h0000);
        issue(2'b01, 6'd3, 1'b1, 16'hABCD);
        read_chk("R8 lock blocks write R4", 0, 6'd3, 16'hFFFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule